// File: doc/BRIEF.md
# Memory dependency group tracker

This block keeps a fixed table of memory dependency groups for an out-of-order scheduler model. A group collects memory operations that do not depend on one another and share the same set of older groups they must wait for. For every group the block counts its predecessors and how many of them have started or finished, its member operations and how many of those are issued or completed. It also keeps a mask of successor groups. From those counts it reports a five-way status per group: waiting, pending, ready, executing and executed.

One event is presented per clock on `op_i`, together with a group id, an optional second id and a latency value. A per-cycle tick can accompany any event. When a group's members are all in flight, every successor learns that one more predecessor has started. When the last member completes, every successor moves that predecessor from started to finished. Each group also carries a critical latency estimate. It is taken from the largest remaining latency among the members of a predecessor group at the moment that group starts, and it counts down while the group still waits.

An event that breaks the rules leaves every group untouched and sets a sticky error flag.

Top module: `mdg_tracker`

## Requirements
- R1: Create (op code 1) allocates ids in increasing order starting at 1; `next_id_o` shows the id the next create will take. After all 8 ids are used, `next_id_o` reads 0 and a further create is rejected.
- R2: A valid group is waiting when its predecessor count exceeds the sum of its started-predecessor and finished-predecessor counts; exactly one of waiting, pending and ready is set for every valid group, and none for an unallocated slot.
- R3: A valid group is pending when its started-predecessor count is nonzero and started plus finished predecessors equal its predecessor count.
- R4: A valid group is ready when its finished-predecessor count equals its predecessor count, so a freshly created group is ready at once.
- R5: A group is executing when its issued count is nonzero and equals members minus completed, and executed when completed equals members; a new empty group is executed and not executing.
- R6: When a group becomes executing (issue, op code 4, of its last unissued member), each successor's started-predecessor count rises by one; when it becomes executed (complete, op code 5, of its last member), each successor moves one count from started to finished.
- R7: Link (op code 3, `grp_i` the predecessor, `succ_i` the successor) raises the successor's predecessor count; if the predecessor is executing at that moment, the successor counts it as started in the same cycle.
- R8: Add member (op code 2) is rejected when the group already has a successor or already holds 15 members.
- R9: A group keeps the largest `lat_i` seen on its issues. When it becomes executing, or is linked while executing, each affected successor's critical latency becomes the larger of its current value and that maximum. On a cycle with `tick_i` high, a waiting group with a nonzero critical latency decrements it by one before any such raise.
- R10: A rejected event sets `error_o`, which stays set until reset, and changes no group state. Rejected events are: any event naming an unallocated id or id 0; issue or complete on a group that is not ready; issue when no member is left unissued; complete when none is issued; a link to itself, from an executed group, a repeated link, or to a group with 15 predecessors. Op codes 0, 6 and 7 have no effect.
- R11: After reset no group is valid, all status outputs and critical latencies are 0, `next_id_o` is 1 and `error_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Event code: 0 none, 1 create, 2 add member, 3 link, 4 issue, 5 complete |
| grp_i | input | 4 | Target group id (predecessor for link) |
| succ_i | input | 4 | Successor group id for link |
| lat_i | input | 6 | Remaining latency carried by an issue |
| tick_i | input | 1 | Per-cycle countdown strobe |
| next_id_o | output | 4 | Id the next create will assign, 0 when exhausted |
| valid_o | output | 8 | Slot allocated, bit i for id i+1 |
| waiting_o | output | 8 | Waiting status per group |
| pending_o | output | 8 | Pending status per group |
| ready_o | output | 8 | Ready status per group |
| executing_o | output | 8 | Executing status per group |
| executed_o | output | 8 | Executed status per group |
| crit_lat_o | output | 48 | Critical latency per group, 6 bits each, group i at bits 6i+5..6i |
| error_o | output | 1 | Sticky rejected-event flag |

## Verification
On every cycle the assertions hold the count invariants: started plus finished predecessors never exceed predecessors, and issued plus completed never exceed members. They also check that waiting, pending and ready stay mutually exclusive, that the error flag stays set, that ids advance by one, that the countdown steps by one, and that members are only added to groups without successors. Only the bench's scenarios can show that start and finish notifications reach the right successors and are counted once. The same goes for linking to a group already in flight, the interplay of countdown and latency raise in one cycle, and that rejected events truly leave every group unchanged. Those are compared against an arithmetic model of the counters over directed graphs, member-count sweeps and a long pseudo-random event stream.

// File: rtl/mdg_pkg.sv
package mdg_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_CREATE = 3'd1,
    OP_ADD    = 3'd2,
    OP_LINK   = 3'd3,
    OP_ISSUE  = 3'd4,
    OP_DONE   = 3'd5
  } op_e;
endpackage

// File: rtl/mdg_status.sv
module mdg_status #(
  parameter int CNT_W = 4
) (
  input  logic             valid_i,
  input  logic [CNT_W-1:0] npred_i,
  input  logic [CNT_W-1:0] nstart_i,
  input  logic [CNT_W-1:0] nfin_i,
  input  logic [CNT_W-1:0] nmem_i,
  input  logic [CNT_W-1:0] niss_i,
  input  logic [CNT_W-1:0] ncmp_i,
  output logic             waiting_o,
  output logic             pending_o,
  output logic             ready_o,
  output logic             executing_o,
  output logic             executed_o
);
  logic [CNT_W:0]   seen;
  logic [CNT_W-1:0] open_cnt;

  assign seen     = {1'b0, nstart_i} + {1'b0, nfin_i};
  assign open_cnt = nmem_i - ncmp_i;

  assign waiting_o   = valid_i && ({1'b0, npred_i} > seen);
  assign pending_o   = valid_i && (nstart_i != '0) && (seen == {1'b0, npred_i});
  assign ready_o     = valid_i && (nfin_i == npred_i);
  assign executing_o = valid_i && (niss_i != '0) && (niss_i == open_cnt);
  assign executed_o  = valid_i && (ncmp_i == nmem_i);
endmodule

// File: rtl/mdg_group.sv
module mdg_group #(
  parameter int CNT_W = 4,
  parameter int LAT_W = 6,
  parameter int N     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             create_i,
  input  logic             add_i,
  input  logic             issue_i,
  input  logic             done_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             link_pred_i,
  input  logic [N-1:0]     succ_set_i,
  input  logic             pred_start_i,
  input  logic [LAT_W-1:0] pred_lat_i,
  input  logic             pred_finish_i,
  input  logic             tick_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] npred_o,
  output logic [CNT_W-1:0] nmem_o,
  output logic [CNT_W-1:0] niss_o,
  output logic [CNT_W-1:0] ncmp_o,
  output logic [N-1:0]     succ_o,
  output logic [LAT_W-1:0] mlat_o,
  output logic [LAT_W-1:0] crit_o,
  output logic             waiting_o,
  output logic             pending_o,
  output logic             ready_o,
  output logic             executing_o,
  output logic             executed_o
);
  logic             valid_q;
  logic [CNT_W-1:0] npred_q, nstart_q, nfin_q, nmem_q, niss_q, ncmp_q;
  logic [N-1:0]     succ_q;
  logic [LAT_W-1:0] mlat_q, crit_q, crit_dec, crit_nxt;

  mdg_status #(.CNT_W(CNT_W)) i_status (
    .valid_i    (valid_q),
    .npred_i    (npred_q),
    .nstart_i   (nstart_q),
    .nfin_i     (nfin_q),
    .nmem_i     (nmem_q),
    .niss_i     (niss_q),
    .ncmp_i     (ncmp_q),
    .waiting_o  (waiting_o),
    .pending_o  (pending_o),
    .ready_o    (ready_o),
    .executing_o(executing_o),
    .executed_o (executed_o)
  );

  // countdown first, then raise to the incoming predecessor estimate
  always_comb begin
    crit_dec = (tick_i && waiting_o && crit_q != '0) ? crit_q - 1'b1 : crit_q;
    crit_nxt = crit_dec;
    if (pred_start_i && pred_lat_i > crit_dec) crit_nxt = pred_lat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      npred_q  <= '0;
      nstart_q <= '0;
      nfin_q   <= '0;
      nmem_q   <= '0;
      niss_q   <= '0;
      ncmp_q   <= '0;
      succ_q   <= '0;
      mlat_q   <= '0;
      crit_q   <= '0;
    end else if (create_i) begin
      valid_q  <= 1'b1;
      npred_q  <= '0;
      nstart_q <= '0;
      nfin_q   <= '0;
      nmem_q   <= '0;
      niss_q   <= '0;
      ncmp_q   <= '0;
      succ_q   <= '0;
      mlat_q   <= '0;
      crit_q   <= '0;
    end else if (valid_q) begin
      if (add_i) nmem_q <= nmem_q + 1'b1;
      if (issue_i) begin
        niss_q <= niss_q + 1'b1;
        if (lat_i > mlat_q) mlat_q <= lat_i;
      end
      if (done_i) begin
        niss_q <= niss_q - 1'b1;
        ncmp_q <= ncmp_q + 1'b1;
      end
      if (link_pred_i) npred_q <= npred_q + 1'b1;
      succ_q <= succ_q | succ_set_i;
      if (pred_start_i) nstart_q <= nstart_q + 1'b1;
      if (pred_finish_i) begin
        nstart_q <= nstart_q - 1'b1;
        nfin_q   <= nfin_q + 1'b1;
      end
      crit_q <= crit_nxt;
    end
  end

  assign valid_o = valid_q;
  assign npred_o = npred_q;
  assign nmem_o  = nmem_q;
  assign niss_o  = niss_q;
  assign ncmp_o  = ncmp_q;
  assign succ_o  = succ_q;
  assign mlat_o  = mlat_q;
  assign crit_o  = crit_q;

  assert_pred_sum_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> ({1'b0, nstart_q} + {1'b0, nfin_q}) <= {1'b0, npred_q});

  assert_member_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> ({1'b0, niss_q} + {1'b0, ncmp_q}) <= {1'b0, nmem_q});

  assert_one_class_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $countones({waiting_o, pending_o, ready_o}) == 1);

  assert_crit_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !create_i && tick_i && waiting_o && crit_q != '0 && !pred_start_i)
      |=> crit_q == $past(crit_q) - 1'b1);

  assert_add_leaf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |-> succ_q == '0);

  assert_done_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i || issue_i) |-> ready_o);
endmodule

// File: rtl/mdg_tracker.sv
module mdg_tracker #(
  parameter int N     = 8,
  parameter int CNT_W = 4,
  parameter int LAT_W = 6,
  localparam int ID_W  = $clog2(N + 1),
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         op_i,
  input  logic [ID_W-1:0]    grp_i,
  input  logic [ID_W-1:0]    succ_i,
  input  logic [LAT_W-1:0]   lat_i,
  input  logic               tick_i,
  output logic [ID_W-1:0]    next_id_o,
  output logic [N-1:0]       valid_o,
  output logic [N-1:0]       waiting_o,
  output logic [N-1:0]       pending_o,
  output logic [N-1:0]       ready_o,
  output logic [N-1:0]       executing_o,
  output logic [N-1:0]       executed_o,
  output logic [N*LAT_W-1:0] crit_lat_o,
  output logic               error_o
);
  import mdg_pkg::*;

  op_e op;
  assign op = op_e'(op_i);

  logic [CNT_W-1:0] npred_a [N];
  logic [CNT_W-1:0] nmem_a  [N];
  logic [CNT_W-1:0] niss_a  [N];
  logic [CNT_W-1:0] ncmp_a  [N];
  logic [N-1:0]     succ_a  [N];
  logic [LAT_W-1:0] mlat_a  [N];

  logic [ID_W-1:0]  next_id_q;
  logic             error_q;

  // id decode
  logic             g_in, s_in, g_valid, s_valid;
  logic [IDX_W-1:0] g_idx, s_idx;
  logic [N-1:0]     s_onehot;

  assign g_in  = (grp_i != '0) && (grp_i <= ID_W'(N));
  assign s_in  = (succ_i != '0) && (succ_i <= ID_W'(N));
  assign g_idx = g_in ? IDX_W'(grp_i - ID_W'(1)) : '0;
  assign s_idx = s_in ? IDX_W'(succ_i - ID_W'(1)) : '0;
  assign g_valid  = g_in && valid_o[g_idx];
  assign s_valid  = s_in && valid_o[s_idx];
  assign s_onehot = {{(N-1){1'b0}}, 1'b1} << s_idx;

  // selected predecessor view
  logic [CNT_W-1:0] g_nmem, g_niss, g_ncmp, g_open, s_npred;
  logic [N-1:0]     g_succ;
  logic [LAT_W-1:0] g_mlat, new_mlat;
  logic             g_ready, g_exec, g_done;

  assign g_nmem   = nmem_a[g_idx];
  assign g_niss   = niss_a[g_idx];
  assign g_ncmp   = ncmp_a[g_idx];
  assign g_succ   = succ_a[g_idx];
  assign g_mlat   = mlat_a[g_idx];
  assign s_npred  = npred_a[s_idx];
  assign g_open   = g_nmem - g_ncmp;
  assign g_ready  = ready_o[g_idx];
  assign g_exec   = executing_o[g_idx];
  assign g_done   = executed_o[g_idx];
  assign new_mlat = (lat_i > g_mlat) ? lat_i : g_mlat;

  // event qualification
  logic create_ok, add_ok, link_ok, issue_ok, done_ok, ev_any, ev_ok;
  logic becomes_exec, becomes_done;

  assign create_ok = (op == OP_CREATE) && (next_id_q != '0);
  assign add_ok    = (op == OP_ADD) && g_valid && (g_succ == '0) && (g_nmem != '1);
  assign link_ok   = (op == OP_LINK) && g_valid && s_valid && (g_idx != s_idx) &&
                     !g_done && !g_succ[s_idx] && (s_npred != '1);
  assign issue_ok  = (op == OP_ISSUE) && g_valid && g_ready && (g_niss != g_open);
  assign done_ok   = (op == OP_DONE) && g_valid && g_ready && (g_niss != '0);

  assign ev_any = (op == OP_CREATE) || (op == OP_ADD) || (op == OP_LINK) ||
                  (op == OP_ISSUE) || (op == OP_DONE);
  assign ev_ok  = create_ok || add_ok || link_ok || issue_ok || done_ok;

  assign becomes_exec = issue_ok && ((g_niss + CNT_W'(1)) == g_open);
  assign becomes_done = done_ok && ((g_ncmp + CNT_W'(1)) == g_nmem);

  for (genvar j = 0; j < N; j++) begin : g_slot
    logic create_j, add_j, issue_j, done_j, link_pred_j, start_j, finish_j;
    logic [N-1:0]     succ_set_j;
    logic [LAT_W-1:0] start_lat_j;

    assign create_j    = create_ok && (next_id_q == ID_W'(j + 1));
    assign add_j       = add_ok && (g_idx == IDX_W'(j));
    assign issue_j     = issue_ok && (g_idx == IDX_W'(j));
    assign done_j      = done_ok && (g_idx == IDX_W'(j));
    assign link_pred_j = link_ok && (s_idx == IDX_W'(j));
    assign succ_set_j  = (link_ok && g_idx == IDX_W'(j)) ? s_onehot : '0;
    assign start_j     = (becomes_exec && g_succ[j]) || (link_pred_j && g_exec);
    assign start_lat_j = becomes_exec ? new_mlat : g_mlat;
    assign finish_j    = becomes_done && g_succ[j];

    mdg_group #(.CNT_W(CNT_W), .LAT_W(LAT_W), .N(N)) i_group (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .create_i     (create_j),
      .add_i        (add_j),
      .issue_i      (issue_j),
      .done_i       (done_j),
      .lat_i        (lat_i),
      .link_pred_i  (link_pred_j),
      .succ_set_i   (succ_set_j),
      .pred_start_i (start_j),
      .pred_lat_i   (start_lat_j),
      .pred_finish_i(finish_j),
      .tick_i       (tick_i),
      .valid_o      (valid_o[j]),
      .npred_o      (npred_a[j]),
      .nmem_o       (nmem_a[j]),
      .niss_o       (niss_a[j]),
      .ncmp_o       (ncmp_a[j]),
      .succ_o       (succ_a[j]),
      .mlat_o       (mlat_a[j]),
      .crit_o       (crit_lat_o[j*LAT_W +: LAT_W]),
      .waiting_o    (waiting_o[j]),
      .pending_o    (pending_o[j]),
      .ready_o      (ready_o[j]),
      .executing_o  (executing_o[j]),
      .executed_o   (executed_o[j])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_id_q <= ID_W'(1);
      error_q   <= 1'b0;
    end else begin
      if (create_ok) next_id_q <= (next_id_q == ID_W'(N)) ? '0 : next_id_q + 1'b1;
      if (ev_any && !ev_ok) error_q <= 1'b1;
    end
  end

  assign next_id_o = next_id_q;
  assign error_o   = error_q;

  assert_id_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (create_ok && next_id_q != ID_W'(N)) |=> next_id_q == $past(next_id_q) + 1'b1);

  assert_id_exhaust_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_CREATE && next_id_q == '0) |=> error_q);

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_q |=> error_q);

  assert_status_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((waiting_o | pending_o | ready_o | executing_o | executed_o) & ~valid_o) == '0);
endmodule

// File: tb/test_mdg_tracker.sv
module test_mdg_tracker;
  localparam int N    = 8;
  localparam int LW   = 6;
  localparam int IW   = 4;
  localparam int CMAX = 15;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    op_i = '0;
  logic [IW-1:0] grp_i = '0, succ_i = '0;
  logic [LW-1:0] lat_i = '0;
  logic          tick_i = 1'b0;
  logic [IW-1:0] next_id_o;
  logic [N-1:0]  valid_o, waiting_o, pending_o, ready_o, executing_o, executed_o;
  logic [N*LW-1:0] crit_lat_o;
  logic          error_o;

  int n_vec = 0, n_bad = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  mdg_tracker i_mdg_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .grp_i(grp_i), .succ_i(succ_i),
    .lat_i(lat_i), .tick_i(tick_i), .next_id_o(next_id_o), .valid_o(valid_o),
    .waiting_o(waiting_o), .pending_o(pending_o), .ready_o(ready_o),
    .executing_o(executing_o), .executed_o(executed_o), .crit_lat_o(crit_lat_o),
    .error_o(error_o)
  );

  // arithmetic model of the counters
  bit       m_val [N];
  int       m_npred[N], m_nst[N], m_nfin[N], m_mem[N], m_iss[N], m_cmp[N], m_mlat[N], m_crit[N];
  bit [N-1:0] m_succ[N];
  int       m_next;
  bit       m_err;

  function automatic bit f_wait(int j);  return m_val[j] && m_npred[j] > m_nst[j] + m_nfin[j]; endfunction
  function automatic bit f_pend(int j);  return m_val[j] && m_nst[j] != 0 && m_nst[j] + m_nfin[j] == m_npred[j]; endfunction
  function automatic bit f_ready(int j); return m_val[j] && m_nfin[j] == m_npred[j]; endfunction
  function automatic bit f_exing(int j); return m_val[j] && m_iss[j] != 0 && m_iss[j] == m_mem[j] - m_cmp[j]; endfunction
  function automatic bit f_exed(int j);  return m_val[j] && m_cmp[j] == m_mem[j]; endfunction

  task automatic model_clear(int j);
    m_npred[j] = 0; m_nst[j] = 0; m_nfin[j] = 0; m_mem[j] = 0; m_iss[j] = 0;
    m_cmp[j] = 0; m_mlat[j] = 0; m_crit[j] = 0; m_succ[j] = '0;
  endtask

  task automatic model_step(int op, int g, int s, int lat, int tk);
    int gi = g - 1, si = s - 1;
    bit gv, sv, ok, was_ex;
    int nc[N];
    gv = (g >= 1 && g <= N) ? m_val[gi] : 1'b0;
    sv = (s >= 1 && s <= N) ? m_val[si] : 1'b0;
    for (int j = 0; j < N; j++)
      nc[j] = (tk != 0 && f_wait(j) && m_crit[j] != 0) ? m_crit[j] - 1 : m_crit[j];
    ok = 1'b1;
    case (op)
      1: if (m_next != 0) begin
           model_clear(m_next - 1); m_val[m_next - 1] = 1'b1; nc[m_next - 1] = 0;
           m_next = (m_next == N) ? 0 : m_next + 1;
         end else ok = 1'b0;
      2: begin
           ok = gv && m_succ[gi] == '0 && m_mem[gi] != CMAX;
           if (ok) m_mem[gi]++;
         end
      3: begin
           ok = gv && sv && gi != si && !f_exed(gi) && !m_succ[gi][si] && m_npred[si] != CMAX;
           if (ok) begin
             was_ex = f_exing(gi);
             m_npred[si]++; m_succ[gi][si] = 1'b1;
             if (was_ex) begin
               m_nst[si]++;
               if (m_mlat[gi] > nc[si]) nc[si] = m_mlat[gi];
             end
           end
         end
      4: begin
           ok = gv && f_ready(gi) && m_iss[gi] != m_mem[gi] - m_cmp[gi];
           if (ok) begin
             m_iss[gi]++;
             if (lat > m_mlat[gi]) m_mlat[gi] = lat;
             if (m_iss[gi] == m_mem[gi] - m_cmp[gi])
               for (int j = 0; j < N; j++) if (m_succ[gi][j]) begin
                 m_nst[j]++;
                 if (m_mlat[gi] > nc[j]) nc[j] = m_mlat[gi];
               end
           end
         end
      5: begin
           ok = gv && f_ready(gi) && m_iss[gi] != 0;
           if (ok) begin
             m_iss[gi]--; m_cmp[gi]++;
             if (m_cmp[gi] == m_mem[gi])
               for (int j = 0; j < N; j++) if (m_succ[gi][j]) begin
                 m_nst[j]--; m_nfin[j]++;
               end
           end
         end
      default: ;
    endcase
    if (!ok) m_err = 1'b1;
    for (int j = 0; j < N; j++) m_crit[j] = nc[j];
  endtask

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    logic [N-1:0] ev, ew, ep, er, ex, ed;
    logic [N*LW-1:0] ec;
    for (int j = 0; j < N; j++) begin
      ev[j] = m_val[j]; ew[j] = f_wait(j); ep[j] = f_pend(j); er[j] = f_ready(j);
      ex[j] = f_exing(j); ed[j] = f_exed(j); ec[j*LW +: LW] = LW'(m_crit[j]);
    end
    check(req, "status", 64'({valid_o, waiting_o, pending_o, ready_o, executing_o, executed_o}),
          64'({ev, ew, ep, er, ex, ed}));
    check(req, "crit", 64'(crit_lat_o), 64'(ec));
    check(req, "next_id", 64'(next_id_o), 64'(m_next));
    check(req, "error", 64'(error_o), 64'(m_err));
  endtask

  task automatic ev(string req, int op, int g = 0, int s = 0, int lat = 0, int tk = 0);
    @(negedge clk);
    op_i = 3'(op); grp_i = IW'(g); succ_i = IW'(s); lat_i = LW'(lat); tick_i = tk[0];
    model_step(op, g, s, lat, tk);
    @(posedge clk); #1;
    compare(req);
    op_i = '0; tick_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; op_i = '0; tick_i = 1'b0;
    for (int j = 0; j < N; j++) begin model_clear(j); m_val[j] = 1'b0; end
    m_next = 1; m_err = 1'b0;
    @(negedge clk); #1;
    compare("R11");
    rst_ni = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  end

  initial begin
    int unsigned r;
    do_reset();
    ev("R11", 0);

    // R1: ids in order and exhaustion
    for (int k = 0; k < N; k++) begin
      check("R1", "next id before create", 64'(next_id_o), 64'(k + 1));
      ev("R1", 1);
    end
    check("R1", "exhausted id", 64'(next_id_o), 64'(0));
    ev("R1", 1);
    check("R1", "reject create", 64'(error_o), 64'(1));

    // chain with two predecessors: R2 R3 R4 R6 R9
    do_reset();
    ev("R4", 1); ev("R4", 1); ev("R4", 1);
    check("R4", "fresh ready", 64'(ready_o), 64'(8'h07));
    check("R5", "empty executed", 64'(executed_o), 64'(8'h07));
    ev("R5", 2, 1); ev("R5", 2, 1); ev("R5", 2, 3);
    ev("R7", 3, 1, 2); ev("R7", 3, 3, 2);
    ev("R2", 2, 2);
    check("R2", "grp2 waiting", 64'(waiting_o[1]), 64'(1));
    ev("R5", 4, 1, 0, 5);
    check("R5", "partial not executing", 64'(executing_o[0]), 64'(0));
    ev("R6", 4, 1, 0, 9);
    check("R9", "crit raised", 64'(crit_lat_o[LW +: LW]), 64'(9));
    for (int t = 0; t < 4; t++) ev("R9", 0, 0, 0, 0, 1);
    check("R9", "crit counted down", 64'(crit_lat_o[LW +: LW]), 64'(5));
    ev("R3", 4, 3, 0, 3, 1);
    check("R3", "grp2 pending", 64'(pending_o[1]), 64'(1));
    ev("R9", 0, 0, 0, 0, 1);
    check("R9", "no countdown when pending", 64'(crit_lat_o[LW +: LW]), 64'(4));
    ev("R6", 5, 1); ev("R6", 5, 1); ev("R6", 5, 3);
    check("R6", "grp2 ready", 64'(ready_o[1]), 64'(1));
    ev("R5", 4, 2, 0, 2); ev("R5", 5, 2);
    check("R5", "grp2 executed", 64'(executed_o[1]), 64'(1));

    // R7: link to a group already executing
    do_reset();
    ev("R7", 1); ev("R7", 1); ev("R7", 2, 1); ev("R7", 4, 1, 0, 7);
    ev("R7", 3, 1, 2);
    check("R7", "pending at once", 64'(pending_o[1]), 64'(1));
    check("R7", "crit from link", 64'(crit_lat_o[LW +: LW]), 64'(7));

    // R8: add to a group with successors
    do_reset();
    ev("R8", 1); ev("R8", 1); ev("R8", 2, 1); ev("R8", 3, 1, 2);
    ev("R8", 2, 1);
    check("R8", "add rejected", 64'(error_o), 64'(1));

    // R10: rejected events leave state untouched
    do_reset();
    ev("R10", 1); ev("R10", 1); ev("R10", 2, 1); ev("R10", 2, 2); ev("R10", 3, 1, 2);
    ev("R10", 4, 2, 0, 3);
    check("R10", "issue on waiting", 64'(error_o), 64'(1));
    do_reset();
    ev("R10", 1); ev("R10", 2, 1); ev("R10", 5, 1);
    check("R10", "complete none issued", 64'(error_o), 64'(1));
    do_reset();
    ev("R10", 1); ev("R10", 3, 1, 1);
    check("R10", "self link", 64'(error_o), 64'(1));
    do_reset();
    ev("R10", 6, 1); ev("R10", 7, 2); ev("R10", 0, 3);
    check("R10", "unused codes", 64'(error_o), 64'(0));
    ev("R10", 2, 5);
    check("R10", "unallocated id", 64'(error_o), 64'(1));

    // R5: member-count and order sweep
    for (int m = 1; m <= 4; m++)
      for (int ord = 0; ord < 2; ord++) begin
        do_reset();
        ev("R5", 1); ev("R5", 1);
        for (int k = 0; k < m; k++) ev("R5", 2, 1);
        ev("R5", 3, 1, 2);
        for (int k = 0; k < m; k++) begin
          ev("R5", 4, 1, 0, 3 * k + m, 1);
          if (ord == 1) ev("R5", 5, 1, 0, 0, 1);
        end
        for (int k = 0; k < m; k++) ev("R5", 5, 1, 0, 0, 1);
        ev("R6", 4, 2, 0, 1); ev("R6", 5, 2);
      end

    // mixed pseudo-random event stream
    r = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      int opsel, op;
      if (i % 150 == 0) do_reset();
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      opsel = int'(r % 9);
      case (opsel)
        0: op = 1; 1, 2: op = 2; 3: op = 3; 4, 5: op = 4; 6, 7: op = 5; default: op = 0;
      endcase
      ev("R6", op, int'((r >> 4) % 10), int'((r >> 9) % 10), int'((r >> 14) & 63), int'((r >> 21) & 1));
    end

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule